// File: doc/BRIEF.md
# Permuted 3D Element Index Generator

This block turns the linear element counter of a vector loop into a remapped element index. A 32-bit shape word describes a small array of up to three dimensions, a permutation of the order in which those dimensions are walked, and a 3-bit constant offset. Each accepted step strobe produces the next remapped index. Once every element of the array has been visited, the sequence starts again from the offset.

The loop can be resumed after an interruption. A restart request carries a saved linear element index. The generator clears its three dimension counters and walks them forward one position per clock until they match that index, holding `busy` high while it does so. The next step after `busy` drops produces the index for the saved element. Each index is compared against a register-file element limit, and an index that lands beyond the limit raises an overrun flag. The pipeline treats that flag as an illegal-instruction condition.

Top module: `remap_index_gen`

## Requirements
- R1: The remapped index is off + cx + cy*LX + cz*LX*LY, where cx, cy and cz are the current dimension counters and LX, LY and LZ are the decoded lengths. The size fields sit at cfg[6:0] (x), cfg[14:8] (y) and cfg[22:16] (z).
- R2: The offset is {cfg[23], cfg[15], cfg[7]}, with cfg[7] as its least significant bit. The offset is added to every index that is produced.
- R3: Each size field holds its length minus one. A field value of 0 gives a length of 1, and a field value of 2 gives a length of 3.
- R4: When cfg is all zeros, idx_out equals the linear element count since the last restart, counted from 0.
- R5: The permute code in cfg[26:24] selects the walk order, fastest dimension first. The codes map as follows: 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x. The fastest counter increments on every step. A counter that reaches its length returns to 0 and carries into the next counter in the order.
- R6: Permute codes 6 and 7 drive cfg_err high. While cfg_err is high, a step strobe produces no valid and leaves the counters unchanged.
- R7: After LX*LY*LZ steps, the sequence wraps to the index equal to the offset and then repeats.
- R8: overrun_err is high together with idx_valid exactly when the produced index is greater than or equal to elem_limit.
- R9: After a restart with resume_idx = n and the end of busy, the next accepted step produces the index of linear element n.
- R10: busy is high in the cycle after a restart and stays high until the counters are rebuilt. A step strobe while busy is high produces no valid and does not advance the sequence.
- R11: idx_out is registered, and idx_valid is high for one cycle after each accepted step. After reset, idx_valid, overrun_err and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 32 | Shape word: sizes, offset bits and permute code |
| restart | input | 1 | Start or resume request |
| resume_idx | input | IDX_W | Saved linear element index, used on restart |
| step | input | 1 | Advance one element |
| elem_limit | input | IDX_W | Number of addressable elements in the register file |
| idx_out | output | IDX_W | Remapped element index |
| idx_valid | output | 1 | idx_out is new this cycle |
| overrun_err | output | 1 | Produced index is at or beyond elem_limit |
| busy | output | 1 | Rebuilding counters after a restart |
| cfg_err | output | 1 | Permute code is illegal |

## Verification
The bench sweeps all six permutation codes over several small shapes, including shapes where one or more dimensions have length 1, and runs each sweep past the array size. A carry chain wired in the wrong order therefore shows up as a misplaced index, and a missing wrap shows up as an index that keeps growing past the array. Each offset bit is exercised on its own, so a swapped bit position produces the wrong first index. Restarts at nonzero saved positions catch a generator that restarts from zero. Illegal codes, and steps issued while busy, are checked for stray valids and for counters that moved when they should not have. A limit placed inside the index range tests the boundary of the overrun comparison at equality.

// File: rtl/remap_index_gen.sv
module remap_index_gen #(
  parameter int IDX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg,
  input  logic             restart,
  input  logic [IDX_W-1:0] resume_idx,
  input  logic             step,
  input  logic [IDX_W-1:0] elem_limit,
  output logic [IDX_W-1:0] idx_out,
  output logic             idx_valid,
  output logic             overrun_err,
  output logic             busy,
  output logic             cfg_err
);
  localparam int SZ_W = 7;

  logic [2:0][SZ_W-1:0] sz, cnt, cnt_nx;
  logic [2:0][1:0]      ord;
  logic [2:0]           offs, perm;
  logic [IDX_W-1:0]     lin, tgt, lx, ly, mapped, cur_idx;
  logic                 linear_mode, take_step;

  assign sz[0]       = cfg[6:0];
  assign sz[1]       = cfg[14:8];
  assign sz[2]       = cfg[22:16];
  assign offs        = {cfg[23], cfg[15], cfg[7]};
  assign perm        = cfg[26:24];
  assign cfg_err     = perm > 3'd5;
  assign linear_mode = (cfg == 32'd0);
  assign take_step   = step && !restart && !busy && !cfg_err;

  always_comb begin
    case (perm)
      3'd1:    ord = {2'd1, 2'd2, 2'd0};
      3'd2:    ord = {2'd2, 2'd0, 2'd1};
      3'd3:    ord = {2'd0, 2'd2, 2'd1};
      3'd4:    ord = {2'd1, 2'd0, 2'd2};
      3'd5:    ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
  end

  always_comb begin
    logic carry;
    cnt_nx = cnt;
    carry  = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (carry) begin
        if (cnt[ord[k]] == sz[ord[k]]) begin
          cnt_nx[ord[k]] = '0;
        end else begin
          cnt_nx[ord[k]] = cnt[ord[k]] + 1'b1;
          carry = 1'b0;
        end
      end
    end
  end

  assign lx      = IDX_W'(sz[0]) + 1'b1;
  assign ly      = IDX_W'(sz[1]) + 1'b1;
  assign mapped  = IDX_W'(offs) + IDX_W'(cnt[0]) + IDX_W'(cnt[1]) * lx
                 + IDX_W'(cnt[2]) * lx * ly;
  assign cur_idx = linear_mode ? lin : mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      lin         <= '0;
      tgt         <= '0;
      busy        <= 1'b0;
      idx_out     <= '0;
      idx_valid   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      idx_valid   <= 1'b0;
      overrun_err <= 1'b0;
      if (restart) begin
        cnt  <= '0;
        lin  <= '0;
        tgt  <= resume_idx;
        busy <= 1'b1;
      end else if (busy) begin
        if (lin == tgt) begin
          busy <= 1'b0;
        end else begin
          cnt <= cnt_nx;
          lin <= lin + 1'b1;
        end
      end else if (take_step) begin
        idx_out     <= cur_idx;
        idx_valid   <= 1'b1;
        overrun_err <= (cur_idx >= elem_limit);
        cnt         <= cnt_nx;
        lin         <= lin + 1'b1;
      end
    end
  end

  assert_step_gives_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !busy && !cfg_err) |=> idx_valid);

  assert_illegal_code_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !busy && cfg_err) |=> !idx_valid);

  assert_busy_blocks_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !restart) |=> !idx_valid);

  assert_restart_sets_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> busy);

  assert_overrun_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |-> (idx_valid && idx_out >= $past(elem_limit)));
endmodule

// File: tb/remap_index_gen_bench.sv
`timescale 1ns/1ps
module remap_index_gen_bench;
  localparam int IDX_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      cfg = '0;
  logic             restart = 1'b0;
  logic [IDX_W-1:0] resume_idx = '0;
  logic             step = 1'b0;
  logic [IDX_W-1:0] elem_limit = '1;
  logic [IDX_W-1:0] idx_out;
  logic             idx_valid, overrun_err, busy, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  remap_index_gen #(.IDX_W(IDX_W)) u_remap_index_gen (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .restart(restart),
    .resume_idx(resume_idx), .step(step), .elem_limit(elem_limit),
    .idx_out(idx_out), .idx_valid(idx_valid), .overrun_err(overrun_err),
    .busy(busy), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] mk(int xs, int ys, int zs, int pc, int off);
    logic [31:0] c = '0;
    c[6:0] = 7'(xs); c[14:8] = 7'(ys); c[22:16] = 7'(zs);
    c[26:24] = 3'(pc);
    c[7] = off[0]; c[15] = off[1]; c[23] = off[2];
    return c;
  endfunction

  function automatic int model(logic [31:0] c, int n);
    int len[3];
    int o[3];
    int v[3];
    int m, off;
    if (c == 32'd0) return n;
    len[0] = int'(c[6:0]) + 1;
    len[1] = int'(c[14:8]) + 1;
    len[2] = int'(c[22:16]) + 1;
    off = int'({c[23], c[15], c[7]});
    case (int'(c[26:24]))
      1: o = '{0, 2, 1};
      2: o = '{1, 0, 2};
      3: o = '{1, 2, 0};
      4: o = '{2, 0, 1};
      5: o = '{2, 1, 0};
      default: o = '{0, 1, 2};
    endcase
    m = n % (len[0] * len[1] * len[2]);
    v[o[0]] = m % len[o[0]];
    v[o[1]] = (m / len[o[0]]) % len[o[1]];
    v[o[2]] = m / (len[o[0]] * len[o[1]]);
    return off + v[0] + v[1] * len[0] + v[2] * len[0] * len[1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_restart(input int n, input bit poke);
    @(negedge clk); restart = 1'b1; resume_idx = IDX_W'(n);
    @(negedge clk); restart = 1'b0;
    chk(busy == 1'b1, "R10 busy after restart", int'(busy), 1);
    if (poke) begin
      step = 1'b1;
      @(negedge clk); step = 1'b0;
      chk(idx_valid == 1'b0, "R10 step ignored while busy", int'(idx_valid), 0);
    end
    while (busy) @(negedge clk);
  endtask

  task automatic do_step(input int n, input string req);
    int e;
    e = model(cfg, n);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk(idx_valid == 1'b1, {req, " valid"}, int'(idx_valid), 1);
    chk(int'(idx_out) == e, req, int'(idx_out), e);
    chk(overrun_err == (e >= int'(elem_limit)), "R8 overrun flag", int'(overrun_err),
        int'(e >= int'(elem_limit)));
  endtask

  initial begin
    int tot;
    int szs[3][3];
    szs = '{'{2, 1, 3}, '{0, 3, 1}, '{1, 1, 1}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idx_valid == 1'b0, "R11 reset valid", int'(idx_valid), 0);
    chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
    chk(overrun_err == 1'b0, "R11 reset overrun", int'(overrun_err), 0);

    cfg = '0;
    do_restart(0, 1'b0);
    for (int n = 0; n < 20; n++) do_step(n, "R4 linear count");

    cfg = mk(2, 0, 0, 0, 0);
    do_restart(0, 1'b0);
    for (int n = 0; n < 4; n++) do_step(n, "R3 length is field plus one");

    for (int b = 0; b < 3; b++) begin
      cfg = mk(1, 1, 0, 0, 1 << b);
      do_restart(0, 1'b0);
      do_step(0, "R2 offset bit position");
    end

    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 3; s++)
        for (int off = 0; off < 8; off += 5) begin
          cfg = mk(szs[s][0], szs[s][1], szs[s][2], p, off);
          tot = (szs[s][0] + 1) * (szs[s][1] + 1) * (szs[s][2] + 1);
          do_restart(0, 1'b0);
          for (int n = 0; n < tot; n++) do_step(n, "R5 R1 permuted index");
          do_step(tot, "R7 wrap to offset");
          chk(int'(idx_out) == off, "R7 wrap value", int'(idx_out), off);
          for (int n = tot + 1; n < tot + 4; n++) do_step(n, "R7 repeat");
        end

    cfg = mk(2, 1, 3, 3, 0);
    do_restart(0, 1'b0);
    cfg = mk(2, 1, 3, 6, 0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 code 6 flagged", int'(cfg_err), 1);
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk(idx_valid == 1'b0, "R6 no valid on code 6", int'(idx_valid), 0);
    cfg = mk(2, 1, 3, 7, 0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 code 7 flagged", int'(cfg_err), 1);
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk(idx_valid == 1'b0, "R6 no valid on code 7", int'(idx_valid), 0);
    cfg = mk(2, 1, 3, 3, 0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R6 legal code clear", int'(cfg_err), 0);
    do_step(0, "R6 counters unchanged");

    elem_limit = IDX_W'(10);
    cfg = mk(2, 1, 3, 0, 0);
    do_restart(0, 1'b0);
    for (int n = 0; n < 24; n++) do_step(n, "R8 index near limit");
    elem_limit = '1;

    cfg = mk(2, 1, 3, 4, 5);
    do_restart(5, 1'b1);
    for (int n = 5; n < 12; n++) do_step(n, "R9 resume position");
    do_restart(17, 1'b1);
    for (int n = 17; n < 30; n++) do_step(n, "R9 resume past wrap");
    cfg = '0;
    do_restart(9, 1'b0);
    do_step(9, "R9 resume linear");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule